// File: doc/BRIEF.md
# Bitstream Bit-Access Buffer

This block keeps a short window of a compressed-video bitstream and lets a downstream parser read it one bit field at a time. Upstream logic pushes 32-bit words through a valid/ready handshake. The buffer stores them most-significant bit first, so the oldest unread bit is always at the top of the window. The parser issues one request per cycle, made of an operation code and a length n from 1 to 32.

Five operations are available:
- look at the next n bits;
- drop n bits;
- look at the next n bits and drop them in the same cycle;
- skip forward to the next byte boundary;
- look at the n bits that start at the next byte boundary, without moving.

All extraction is done by shifting and masking the window. The buffer asks for a new word whenever half or less of it holds unread bits. When too few bits remain for a request, the request is held off until the feed catches up.

Top module: `bitbuf_top`

## Requirements
- R1: After a synchronous reset the buffer holds no bits: `in_ready` is 1 and `req_ready` is 0 for any request of length 1 or more except the skip operation.
- R2: Operation 0 (look) puts the next n unread bits on `rd_data`, right-aligned, with bits 31..n at zero. It does not move the read position.
- R3: Operation 1 (drop) advances the read position by n bits.
- R4: Operation 2 (take) shows the same `rd_data` as operation 0 would. In the same cycle it advances the read position by n, exactly as operation 0 followed by operation 1 would.
- R5: Operation 3 (skip) is always accepted and ignores n. It advances the read position by the count of unread bits modulo 8, which makes that count a multiple of 8. When the count is already a multiple of 8 it advances by zero bits.
- R6: Operation 4 (aligned look) puts the n bits that begin at the next byte boundary (k = unread count modulo 8 bits ahead) on `rd_data`, right-aligned and zero-filled. It does not move the read position.
- R7: `in_ready` is 1 exactly when 32 or fewer unread bits remain. An accepted word is appended after all existing unread bits, bit 31 first. A word and a consuming request may be accepted in the same cycle.
- R8: `req_ready` is 0 when fewer than n unread bits remain (operations 0–2) or fewer than k+n (operation 4). A request presented while `req_ready` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Incoming stream word, bit 31 earliest |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Buffer can take a word this cycle |
| req_valid | input | 1 | A request is presented |
| req_op | input | 3 | 0 look, 1 drop, 2 take, 3 skip, 4 aligned look |
| req_len | input | 6 | Field length n, 1 to 32 |
| req_ready | output | 1 | Request is served this cycle |
| rd_data | output | 32 | Right-aligned field for look, take and aligned look |

## Verification
The hardest states to reach are the boundary stalls:
- an aligned look whose skip distance k plus n just exceeds the unread count;
- a take that drains the window to exactly zero while a word arrives in the same cycle.

With the feed running, the window stays nearly full and these states never occur. The stimulus therefore runs a second phase with the feed mostly withheld. In that phase it sweeps n upward across all five operations, so the unread count falls through every residue modulo 8 and lands on both sides of each ready threshold. A bit-exact reference queue in the bench predicts every field.

// File: rtl/bitbuf_pkg.sv
package bitbuf_pkg;
   typedef enum logic [2:0] {
      OP_LOOK  = 3'd0,
      OP_DROP  = 3'd1,
      OP_TAKE  = 3'd2,
      OP_SKIP  = 3'd3,
      OP_ALOOK = 3'd4
   } bb_op_e;
endpackage

// File: rtl/bitbuf_extract.sv
module bitbuf_extract #(
   parameter int BUF_W  = 64,
   parameter int OUT_W  = 32,
   parameter int SKIP_W = 3,
   parameter bit BARREL = 1'b1,
   localparam int LW    = $clog2(OUT_W + 1)
) (
   input  logic [BUF_W-1:0]  win,
   input  logic [SKIP_W-1:0] skip,
   input  logic [LW-1:0]     len,
   output logic [OUT_W-1:0]  field
);
   initial begin : p_elab
      assert (OUT_W <= BUF_W) else $error("OUT_W exceeds BUF_W");
   end

   logic [BUF_W-1:0] aligned;

   generate
      if (BARREL) begin : g_barrel
         logic [BUF_W-1:0] stage [0:SKIP_W];
         assign stage[0] = win;
         for (genvar i = 0; i < SKIP_W; i++) begin : g_st
            assign stage[i+1] = skip[i] ? (stage[i] << (1 << i)) : stage[i];
         end
         assign aligned = stage[SKIP_W];
      end else begin : g_direct
         assign aligned = win << skip;
      end
   endgenerate

   logic [OUT_W-1:0] top_bits;
   logic [LW-1:0]    rsh;
   assign top_bits = aligned[BUF_W-1 -: OUT_W];
   assign rsh      = LW'(OUT_W) - len;
   assign field    = top_bits >> rsh;
endmodule

// File: rtl/bitbuf_store.sv
module bitbuf_store #(
   parameter int BUF_W = 64,
   parameter int IN_W  = 32,
   parameter int AW    = 6,
   localparam int FW   = $clog2(BUF_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IN_W-1:0]  in_data,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [AW-1:0]    adv,
   output logic [BUF_W-1:0] win,
   output logic [FW-1:0]    fill
);
   initial begin : p_elab
      assert (BUF_W == 2 * IN_W) else $error("BUF_W must be twice IN_W");
      assert (IN_W % 8 == 0) else $error("IN_W must be whole bytes");
   end

   logic             accept;
   logic [FW-1:0]    fill_c;
   logic [BUF_W-1:0] win_sh, ins, win_n;
   logic [FW-1:0]    fill_n;

   assign in_ready = (fill <= FW'(IN_W));
   assign accept   = in_valid && in_ready;

   always_comb begin
      fill_c = fill - FW'(adv);
      win_sh = win << adv;
      ins    = {in_data, {(BUF_W-IN_W){1'b0}}} >> fill_c;
      win_n  = accept ? (win_sh | ins) : win_sh;
      fill_n = accept ? (fill_c + FW'(IN_W)) : fill_c;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win  <= '0;
         fill <= '0;
      end else begin
         win  <= win_n;
         fill <= fill_n;
      end
   end

   a_r7_fill_bound: assert property (@(posedge clk) disable iff (rst)
      fill <= FW'(BUF_W));
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
      FW'(adv) <= fill);
   a_r7_refill_adds: assert property (@(posedge clk) disable iff (rst)
      (accept && adv == '0) |=> fill == $past(fill) + FW'(IN_W));
   a_r3_consume_only: assert property (@(posedge clk) disable iff (rst)
      (!accept) |=> fill == $past(fill) - FW'($past(adv)));
endmodule

// File: rtl/bitbuf_top.sv
module bitbuf_top #(
   parameter int BUF_W  = 64,
   parameter int IN_W   = 32,
   parameter int OUT_W  = 32,
   parameter bit BARREL = 1'b1,
   localparam int LW    = $clog2(OUT_W + 1),
   localparam int FW    = $clog2(BUF_W + 1),
   localparam int SKIP_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IN_W-1:0]   in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [LW-1:0]     req_len,
   output logic              req_ready,
   output logic [OUT_W-1:0]  rd_data
);
   import bitbuf_pkg::*;

   initial begin : p_elab
      assert (OUT_W <= IN_W) else $error("OUT_W must not exceed IN_W");
   end

   logic [BUF_W-1:0]  win;
   logic [FW-1:0]     fill;
   logic [LW-1:0]     adv;
   logic [SKIP_W-1:0] skip, bound;
   logic [FW-1:0]     need;
   logic              fire;
   bb_op_e            op;

   assign op    = bb_op_e'(req_op);
   assign bound = fill[SKIP_W-1:0];

   always_comb begin
      skip = '0;
      need = FW'(req_len);
      adv  = '0;
      unique case (op)
         OP_SKIP:  begin skip = bound; need = '0; end
         OP_ALOOK: begin skip = bound; need = FW'(bound) + FW'(req_len); end
         default:  ;
      endcase
      req_ready = (fill >= need);
      fire      = req_valid && req_ready;
      if (fire) begin
         unique case (op)
            OP_DROP, OP_TAKE: adv = req_len;
            OP_SKIP:          adv = LW'(bound);
            default:          adv = '0;
         endcase
      end
   end

   bitbuf_store #(.BUF_W(BUF_W), .IN_W(IN_W), .AW(LW)) u_store (
      .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .adv(adv), .win(win), .fill(fill)
   );

   bitbuf_extract #(.BUF_W(BUF_W), .OUT_W(OUT_W), .SKIP_W(SKIP_W),
                    .BARREL(BARREL)) u_extract (
      .win(win), .skip(skip), .len(req_len), .field(rd_data)
   );

   a_r8_len_range: assert property (@(posedge clk) disable iff (rst)
      (req_valid && op != OP_SKIP) |-> (req_len >= LW'(1) && req_len <= LW'(OUT_W)));
   a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready && !(in_valid && in_ready)) |=> $stable(fill));
   a_r5_skip_aligns: assert property (@(posedge clk) disable iff (rst)
      (req_valid && op == OP_SKIP) |=> fill[SKIP_W-1:0] == '0);
   a_r2_look_keeps: assert property (@(posedge clk) disable iff (rst)
      (req_valid && (op == OP_LOOK || op == OP_ALOOK) && !(in_valid && in_ready))
      |=> $stable(fill));
endmodule

// File: tb/bitbuf_top_tb.sv
module bitbuf_top_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] in_data;
   logic        in_valid;
   logic        in_ready;
   logic        req_valid;
   logic [2:0]  req_op;
   logic [5:0]  req_len;
   logic        req_ready;
   logic [31:0] rd_data;

   int errors = 0;
   int checks = 0;
   int words  = 0;
   int rp     = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   bitbuf_top u_dut (
      .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .req_valid(req_valid), .req_op(req_op),
      .req_len(req_len), .req_ready(req_ready), .rd_data(rd_data)
   );

   function automatic logic [31:0] word_at(int j);
      return (32'(j) * 32'h9E3779B9) ^ 32'h5A5A1234 ^ (32'(j) << 7);
   endfunction

   function automatic logic sbit(int i);
      logic [31:0] w;
      w = word_at(i / 32);
      return w[31 - (i % 32)];
   endfunction

   function automatic logic [31:0] bits_from(int start, int n);
      logic [31:0] r = '0;
      for (int b = 0; b < n; b++) r = {r[30:0], sbit(start + b)};
      return r;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (rp=%0d words=%0d)",
                  tag, act, exp, rp, words);
      end
   endtask

   task automatic do_op(int op, int n, bit iv);
      int  fill, k, need, adv;
      bit  exp_rdy, exp_in;
      @(negedge clk);
      in_valid  = iv;
      in_data   = word_at(words);
      req_valid = 1'b1;
      req_op    = 3'(op);
      req_len   = 6'(n);
      #1;
      fill    = 32 * words - rp;
      k       = fill % 8;
      need    = (op == 3) ? 0 : ((op == 4) ? k + n : n);
      exp_rdy = (fill >= need);
      exp_in  = (fill <= 32);
      check(in_ready == exp_in, "R7 in_ready", 32'(in_ready), 32'(exp_in));
      check(req_ready == exp_rdy, (op == 3) ? "R5 skip ready" : "R8 req_ready",
            32'(req_ready), 32'(exp_rdy));
      if (exp_rdy) begin
         if (op == 0) check(rd_data == bits_from(rp, n), "R2 look data", rd_data, bits_from(rp, n));
         if (op == 2) check(rd_data == bits_from(rp, n), "R4 take data", rd_data, bits_from(rp, n));
         if (op == 4) check(rd_data == bits_from(rp + k, n), "R6 aligned look data",
                            rd_data, bits_from(rp + k, n));
      end
      adv = 0;
      if (exp_rdy) begin
         if (op == 1 || op == 2) adv = n;
         if (op == 3) adv = k;
      end
      @(posedge clk);
      if (iv && exp_in) words++;
      rp += adv;
   endtask

   initial begin : p_watchdog
      #(20ns * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : p_main
      rst = 1'b1; in_valid = 1'b0; req_valid = 1'b0;
      req_op = '0; req_len = 6'd1; in_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      req_valid = 1'b1; req_op = 3'd0; req_len = 6'd1;
      #1;
      check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
      check(req_ready == 1'b0, "R1 req_ready after reset", 32'(req_ready), 32'd0);
      // R1 skip on empty buffer is accepted and moves nothing
      do_op(3, 5, 0);
      // R8 stall on empty, then R7 fill
      do_op(2, 32, 0);
      do_op(0, 1, 1);
      do_op(0, 32, 1);
      // main sweep, feed mostly on: R2 R3 R4 R5 R6
      for (int op = 0; op < 5; op++)
         for (int n = 1; n <= 32; n++)
            for (int p = 0; p < 3; p++)
               do_op(op, n, p != 1);
      // drain phase, feed mostly off: stalls and aligned-look thresholds (R8 R6)
      for (int n = 1; n <= 32; n++)
         for (int rep = 0; rep < 5; rep++)
            do_op((n + rep) % 5, n, rep == 4);
      for (int n = 1; n <= 32; n++) begin
         do_op(2, n, 0);
         do_op(4, (n * 7) % 32 + 1, 0);
         do_op(3, n, 0);
         do_op(1, 33 - n, n % 4 == 0);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule